// File: doc/BRIEF.md
# Posted Register Write Synchronizer

This block sits between a fast bus clock and a slower functional timer clock and gives software access to a bank of timer registers. Ten of them live in the functional domain. The other three are local to the bus domain: a wakeup-enable register, an interface-control register and a pending-status register.

When posting is on, a write to one of the ten functional registers is accepted on the bus with no wait state. The value is then carried across the clock boundary by a toggle handshake. While that transfer is in flight, the register's own pending bit stays high in the status register. Software polls the status register and waits for the bit to fall before it touches that register again. When posting is off, the bus is held in wait states until the written value has landed in the functional domain.

The block stalls an access to a functional register whose transfer is still pending, rather than dropping the write or returning a stale value. Reads of a functional register return the value held in the functional domain.

Top module: `posted_wr_sync`

## Requirements
- R1: After reset, the status register, the interface-control register, the wakeup-enable register and all ten functional registers read 0. Posting is therefore off after reset.
- R2: The address map is fixed. Index 0 to 9 select the functional registers, in this order: control, counter, load, trigger, match, positive increment, negative increment, tick counter, overflow count, overflow mask. In posted mode, a write to one of them whose pending bit is clear is accepted in the same cycle that `bus_req` rises (zero wait states).
- R3: Pending bit n of the status register (index 12, bits 9..0) belongs to functional register n. It is 1 from the cycle after the write is accepted. It clears only after the handshake has passed two synchronizing flops into the functional domain and two back. With a functional clock three times slower than the bus clock, it clears within 40 bus cycles.
- R4: An access (read or write) to a functional register whose pending bit is set is held with `bus_ready` low until the bit clears. It then completes, and a stalled write is never dropped.
- R5: With posting off (interface-control bit 2 = 0), a write to a functional register holds `bus_ready` low until the value has landed. When it completes, the pending bit already reads 0.
- R6: A read of a functional register returns the value stored in the functional domain, which is the last write that landed.
- R7: The wakeup-enable (index 10, read/write), interface-control (index 11; only bit 2 is stored, and it selects posting) and status (index 12, read-only; writes are ignored) registers respond with zero wait states in both modes.
- R8: A write to one functional register sets only that register's pending bit. At most one transfer is launched per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| brst_n | input | 1 | Bus-domain active-low reset |
| fclk | input | 1 | Functional clock |
| frst_n | input | 1 | Functional-domain active-low reset |
| bus_req | input | 1 | Access request, held until `bus_ready` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (4) | Register index |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, valid while `bus_ready` is high |
| bus_ready | output | 1 | Access completes at the next `bclk` edge |

## Verification
`bus_ready` is combinational. The bench samples it one time unit after the falling edge of `bclk` and counts the wait cycles before it rises. Zero wait cycles are expected for a posted write and for the direct registers. At least three are expected for a non-posted write or a stalled access.

A pending bit is due one bus cycle after the accepting edge. The bench therefore reads the status register in the very next access, when the bit must still be high. It then polls once per bus cycle and expects the bit to fall within 40 polls. Only after that does it read back the functional register and compare it with the written value.

// File: rtl/pwsync_pkg.sv
package pwsync_pkg;
    localparam int unsigned NPOST     = 10;
    localparam int unsigned DW        = 32;
    localparam int unsigned AW        = 4;
    localparam int unsigned IDX_WAKE  = 10;
    localparam int unsigned IDX_IFC   = 11;
    localparam int unsigned IDX_PEND  = 12;
    localparam int unsigned POST_BIT  = 2;

    typedef struct packed {
        logic [DW-1:0] wake;
        logic          posted;
        logic          np_wait;
    } bus_state_t;
endpackage

// File: rtl/pwsync_sync2.sv
module pwsync_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[0], din};
    end

    assign dout = stage_q[1];
endmodule

// File: rtl/pwsync_lane.sv
module pwsync_lane #(
    parameter int unsigned DW = 32
) (
    input  logic          bclk,
    input  logic          brst_n,
    input  logic          fclk,
    input  logic          frst_n,
    input  logic          launch,
    input  logic [DW-1:0] wdata,
    output logic          pending,
    output logic [DW-1:0] fval
);
    // bus side: request toggle and held data
    typedef struct packed {
        logic          tog;
        logic [DW-1:0] hold;
    } bside_t;

    // functional side: seen toggle and stored value
    typedef struct packed {
        logic          seen;
        logic [DW-1:0] val;
    } fside_t;

    bside_t b_d, b_q;
    fside_t f_d, f_q;
    logic   req_f;
    logic   ack_b;

    always_comb begin
        b_d = b_q;
        if (launch) begin
            b_d.tog  = ~b_q.tog;
            b_d.hold = wdata;
        end
    end

    always_ff @(posedge bclk or negedge brst_n) begin
        if (!brst_n) b_q <= '0;
        else         b_q <= b_d;
    end

    pwsync_sync2 u_to_f (.clk(fclk), .rst_n(frst_n), .din(b_q.tog), .dout(req_f));

    always_comb begin
        f_d = f_q;
        if (req_f != f_q.seen) begin
            f_d.seen = req_f;
            f_d.val  = b_q.hold;   // held stable while the toggle is in flight
        end
    end

    always_ff @(posedge fclk or negedge frst_n) begin
        if (!frst_n) f_q <= '0;
        else         f_q <= f_d;
    end

    pwsync_sync2 u_to_b (.clk(bclk), .rst_n(brst_n), .din(f_q.seen), .dout(ack_b));

    assign pending = b_q.tog ^ ack_b;
    assign fval    = f_q.val;
endmodule

// File: rtl/posted_wr_sync.sv
module posted_wr_sync
    import pwsync_pkg::*;
#(
    parameter int unsigned P_NPOST = NPOST,
    parameter int unsigned P_DW    = DW,
    parameter int unsigned P_AW    = AW
) (
    input  logic            bclk,
    input  logic            brst_n,
    input  logic            fclk,
    input  logic            frst_n,
    input  logic            bus_req,
    input  logic            bus_we,
    input  logic [P_AW-1:0] bus_addr,
    input  logic [P_DW-1:0] bus_wdata,
    output logic [P_DW-1:0] bus_rdata,
    output logic            bus_ready
);
    localparam int unsigned IW = $clog2(P_NPOST);

    bus_state_t                    s_d, s_q;
    logic [P_NPOST-1:0]            launch_w;
    logic [P_NPOST-1:0]            pend_w;
    logic [P_NPOST-1:0][P_DW-1:0]  fval_w;
    logic                          is_post;
    logic [IW-1:0]                 idx;
    logic                          posted_mode;

    assign is_post     = (32'(bus_addr) < P_NPOST);
    assign idx         = bus_addr[IW-1:0];
    assign posted_mode = s_q.posted;

    generate
        for (genvar g = 0; g < P_NPOST; g++) begin : g_lane
            pwsync_lane #(.DW(P_DW)) u_lane (
                .bclk   (bclk),
                .brst_n (brst_n),
                .fclk   (fclk),
                .frst_n (frst_n),
                .launch (launch_w[g]),
                .wdata  (bus_wdata),
                .pending(pend_w[g]),
                .fval   (fval_w[g])
            );
        end
    endgenerate

    always_comb begin
        s_d       = s_q;
        launch_w  = '0;
        bus_ready = 1'b0;
        bus_rdata = '0;
        if (bus_req) begin
            if (is_post) begin
                if (pend_w[idx]) begin
                    bus_ready = 1'b0;                 // stall, never drop
                end else if (s_q.np_wait) begin
                    bus_ready = 1'b1;                 // non-posted write landed
                    s_d.np_wait = 1'b0;
                    bus_rdata = fval_w[idx];
                end else if (bus_we) begin
                    launch_w[idx] = 1'b1;
                    if (s_q.posted) bus_ready   = 1'b1;
                    else            s_d.np_wait = 1'b1;
                end else begin
                    bus_ready = 1'b1;
                    bus_rdata = fval_w[idx];
                end
            end else begin
                bus_ready = 1'b1;
                case (32'(bus_addr))
                    IDX_WAKE: begin
                        bus_rdata = s_q.wake;
                        if (bus_we) s_d.wake = bus_wdata;
                    end
                    IDX_IFC: begin
                        bus_rdata[POST_BIT] = s_q.posted;
                        if (bus_we) s_d.posted = bus_wdata[POST_BIT];
                    end
                    IDX_PEND: begin
                        bus_rdata[P_NPOST-1:0] = pend_w;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge bclk or negedge brst_n) begin
        if (!brst_n) s_q <= '0;
        else         s_q <= s_d;
    end
endmodule

// File: rtl/pwsync_checker.sv
module pwsync_checker #(
    parameter int unsigned NP = 10,
    parameter int unsigned AWC = 4
) (
    input logic           bclk,
    input logic           brst_n,
    input logic           bus_req,
    input logic           bus_we,
    input logic [AWC-1:0] bus_addr,
    input logic           bus_ready,
    input logic [NP-1:0]  pend,
    input logic [NP-1:0]  launch,
    input logic           posted_mode
);
    logic post_hit;
    assign post_hit = bus_req && (32'(bus_addr) < NP);

    // R3: a launched transfer shows its pending bit in the next cycle
    assert_pend_set_R3: assert property (@(posedge bclk) disable iff (!brst_n)
        (|launch) |=> ((pend & $past(launch)) == $past(launch)));

    // R4: no access completes while its register is pending
    assert_no_drop_R4: assert property (@(posedge bclk) disable iff (!brst_n)
        (post_hit && pend[bus_addr]) |-> !bus_ready);

    // R5: a non-posted write completes only with its pending bit clear
    assert_np_landed_R5: assert property (@(posedge bclk) disable iff (!brst_n)
        (post_hit && bus_we && bus_ready && !posted_mode) |-> !pend[bus_addr]);

    // R7: direct registers never insert wait states
    assert_direct_zero_wait_R7: assert property (@(posedge bclk) disable iff (!brst_n)
        (bus_req && (32'(bus_addr) >= NP)) |-> bus_ready);

    // R8: at most one launch per cycle
    assert_single_launch_R8: assert property (@(posedge bclk) disable iff (!brst_n)
        $onehot0(launch));
endmodule

bind posted_wr_sync pwsync_checker #(.NP(P_NPOST), .AWC(P_AW)) chk_i (
    .bclk       (bclk),
    .brst_n     (brst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_ready  (bus_ready),
    .pend       (pend_w),
    .launch     (launch_w),
    .posted_mode(posted_mode)
);

// File: tb/posted_wr_sync_tb.sv
module posted_wr_sync_tb_top;
    localparam int NP = 10;

    logic        bclk = 0, fclk = 0, brst_n = 0, frst_n = 0;
    logic        bus_req = 0, bus_we = 0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;

    int checks = 0, fails = 0;

    always #10 bclk = ~bclk;                 // 50 MHz
    initial begin #7; forever #30 fclk = ~fclk; end

    posted_wr_sync dut_i (.*);

    // {index, data}
    localparam logic [35:0] VEC [NP] = '{
        {4'd0, 32'h0000_0003}, {4'd1, 32'hFFFF_FF00}, {4'd2, 32'h1234_5678},
        {4'd3, 32'h0000_0001}, {4'd4, 32'hDEAD_BEEF}, {4'd5, 32'h0000_0232},
        {4'd6, 32'hFFFF_FC18}, {4'd7, 32'h8000_0000}, {4'd8, 32'h0000_00FF},
        {4'd9, 32'h5A5A_A5A5}};

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input bit we, input logic [3:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int waits);
        @(negedge bclk);
        bus_req = 1; bus_we = we; bus_addr = a; bus_wdata = d; waits = 0;
        forever begin
            #1;
            if (bus_ready) break;
            @(negedge bclk);
            waits++;
        end
        rd = bus_rdata;
        @(posedge bclk);
        #1 bus_req = 0; bus_we = 0;
    endtask

    task automatic wait_clear(input int n, output int polls);
        logic [31:0] rd; int w;
        polls = 0;
        do begin
            xfer(0, 4'd12, 0, rd, w);
            polls++;
        end while (rd[n] && polls < 60);
    endtask

    initial begin
        logic [31:0] rd; int w, p;
        #105; brst_n = 1; frst_n = 1;

        // R1: reset state
        xfer(0, 4'd12, 0, rd, w); check(rd == 0, "R1 status", rd, 0);
        xfer(0, 4'd11, 0, rd, w); check(rd == 0, "R1 ifc", rd, 0);
        xfer(0, 4'd10, 0, rd, w); check(rd == 0, "R1 wake", rd, 0);
        xfer(0, 4'd3, 0, rd, w);  check(rd == 0, "R1 reg3", rd, 0);

        // R5: non-posted write stalls until landed
        xfer(1, 4'd4, 32'h0000_AAAA, rd, w);
        check(w >= 3, "R5 waits", w, 3);
        xfer(0, 4'd12, 0, rd, w); check(rd == 0, "R5 pending clear", rd, 0);
        xfer(0, 4'd4, 0, rd, w);  check(rd == 32'h0000_AAAA, "R5 landed", rd, 32'h0000_AAAA);

        // R7: enable posting, zero waits
        xfer(1, 4'd11, 32'h4, rd, w); check(w == 0, "R7 ifc waits", w, 0);
        xfer(0, 4'd11, 0, rd, w);     check(rd == 32'h4, "R7 ifc read", rd, 32'h4);

        // vector walk: R2 R3 R6 R8
        for (int i = 0; i < NP; i++) begin
            logic [3:0]  a = VEC[i][35:32];
            logic [31:0] d = VEC[i][31:0];
            xfer(1, a, d, rd, w);
            check(w == 0, "R2 posted zero wait", w, 0);
            xfer(0, 4'd12, 0, rd, w);
            check(rd == (32'd1 << a), "R3/R8 pending bit", rd, 32'd1 << a);
            wait_clear(a, p);
            check(p < 40, "R3 clear bound", p, 40);
            xfer(0, a, 0, rd, w);
            check(rd == d, "R6 readback", rd, d);
        end

        // R4: back-to-back writes, second stalls and is kept
        xfer(1, 4'd1, 32'h1111_1111, rd, w);
        xfer(1, 4'd1, 32'h2222_2222, rd, w);
        check(w >= 3, "R4 write stall", w, 3);
        wait_clear(1, p);
        xfer(0, 4'd1, 0, rd, w); check(rd == 32'h2222_2222, "R4 not dropped", rd, 32'h2222_2222);

        // R4/R6: read behind a pending write stalls then returns new value
        xfer(1, 4'd2, 32'hCAFE_0002, rd, w);
        xfer(0, 4'd2, 0, rd, w);
        check(w >= 3, "R4 read stall", w, 3);
        check(rd == 32'hCAFE_0002, "R6 read after stall", rd, 32'hCAFE_0002);

        // R7: status is read-only, wake read/write
        xfer(1, 4'd12, 32'hFFFF_FFFF, rd, w); check(w == 0, "R7 status write waits", w, 0);
        xfer(0, 4'd12, 0, rd, w); check(rd == 0, "R7 status write ignored", rd, 0);
        xfer(1, 4'd10, 32'h0000_0007, rd, w);
        xfer(0, 4'd10, 0, rd, w); check(rd == 32'h7, "R7 wake rw", rd, 32'h7);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule